// File: doc/BRIEF.md
# Integer Execute Unit with Trapping Overflow

This block is the integer execute stage of a 64-bit core. Each cycle it can accept one operation: an operation code, a first operand, and a second operand taken either from a register or from an 8-bit literal that is zero-extended. One clock later it returns the result, a register write-enable and an overflow-trap flag. The unit covers these operation groups:

- add and subtract, including forms that scale the first operand by 4 or by 8;
- negate and absolute value;
- AND, OR and XOR, each also in a form that inverts the second operand first;
- three shifts;
- five compares;
- eight conditional moves.

Arithmetic comes in a 64-bit form and a 32-bit form. A 32-bit result is always returned sign-extended from bit 31. A separate trap-enable input selects between the trapping and non-trapping variant of add, subtract and negate. Both variants use the same adder.

The operation code is six bits. Bits 5:3 select a class and bits 2:0 select a function within that class. Class codes not listed below, and functions not listed within a class, are reserved.

Top module: `int_exec_unit`

## Requirements
- R1: After reset, `res_valid`, `wr_en`, `ovf_trap` and `result` are all 0. Each accepted operation (`in_valid`=1) appears on the outputs exactly one cycle later with `res_valid`=1. A cycle with `in_valid`=0 gives `res_valid`=0, `wr_en`=0 and `ovf_trap`=0 in the next cycle.
- R2: When `use_lit`=1, the second operand is `lit` zero-extended to 64 bits and `src_b` is ignored.
- R3: Arithmetic class (op[5:3]=0) with functions add=0 and sub=1 computes a+b or a−b. When `quad`=0, only bits 31:0 of each operand are used and the result is sign-extended from bit 31. When `trap_en`=1, `ovf_trap` is set exactly when the true signed result does not fit the selected width. When `trap_en`=0, `ovf_trap` stays 0.
- R4: Arithmetic functions 2, 3, 4 and 5 compute 4a+b, 8a+b, 4a−b and 8a−b, with the same width rules as R3. They never set `ovf_trap`.
- R5: Arithmetic function 6 (negate) returns 0−b and traps only when `trap_en`=1 and b is the most negative value of the width. Function 7 (absolute value) returns |b| and always traps on the most negative value of the width.
- R6: Logic class (op[5:3]=1) functions: 0 a&b, 1 a&~b, 2 a|b, 3 a|~b, 4 a^b, 5 a^~b.
- R7: Shift class (op[5:3]=2) functions: 0 shift left logical, 1 shift right logical, 2 shift right arithmetic. The shift count is b[5:0]; higher count bits are ignored.
- R8: Compare class (op[5:3]=3) writes exactly 1 or 0 for these tests: 0 a==b, 1 signed a<b, 2 signed a<=b, 3 unsigned a<b, 4 unsigned a<=b.
- R9: Conditional-move class (op[5:3]=4) returns b. `wr_en` is 1 only when a meets the condition selected by the function: 0 ==0, 1 !=0, 2 <0, 3 <=0, 4 >0, 5 >=0, 6 bit 0 clear, 7 bit 0 set.
- R10: `ovf_trap` is never set for the logic, shift, compare or conditional-move classes, and is never set without `res_valid`.
- R11: A reserved code (class 5 to 7, logic function 6 or 7, shift function 3 to 7, compare function 5 to 7) gives `wr_en`=0, `ovf_trap`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 6 | Class in [5:3], function in [2:0] |
| trap_en | input | 1 | Selects the trapping variant of add, subtract and negate |
| quad | input | 1 | 1 selects 64-bit arithmetic, 0 selects 32-bit arithmetic |
| use_lit | input | 1 | Takes the second operand from `lit` |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand from a register |
| lit | input | 8 | Literal second operand |
| res_valid | output | 1 | Registered result is valid |
| result | output | 64 | Registered result |
| wr_en | output | 1 | Destination register write-enable |
| ovf_trap | output | 1 | Overflow exception |

## Verification
The unit holds no state beyond its single output register, so any decode or datapath fault shows up at the ports on the cycle directly after the operation that exercises it.

The following faults produce visible symptoms:
- a mis-steered adder carry or a wrong overflow rule corrupts `ovf_trap` or the upper result bits for the affected width;
- a wrong conditional-move decode appears as a wrong `wr_en`;
- a stale valid bit appears as `res_valid` or `wr_en` asserted one cycle after an idle input.

Random operands are biased toward 0, the width minima and maxima, and out-of-range shift counts, because those values expose most of these faults.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
  typedef logic [2:0] cls_t;
  typedef logic [2:0] fn_t;

  localparam cls_t CLS_ARITH = 3'd0;
  localparam cls_t CLS_LOGIC = 3'd1;
  localparam cls_t CLS_SHIFT = 3'd2;
  localparam cls_t CLS_CMP   = 3'd3;
  localparam cls_t CLS_CMOV  = 3'd4;

  localparam fn_t FN_ADD   = 3'd0;
  localparam fn_t FN_SUB   = 3'd1;
  localparam fn_t FN_S4ADD = 3'd2;
  localparam fn_t FN_S8ADD = 3'd3;
  localparam fn_t FN_S4SUB = 3'd4;
  localparam fn_t FN_S8SUB = 3'd5;
  localparam fn_t FN_NEG   = 3'd6;
  localparam fn_t FN_ABS   = 3'd7;

  localparam fn_t FN_AND   = 3'd0;
  localparam fn_t FN_ANDN  = 3'd1;
  localparam fn_t FN_OR    = 3'd2;
  localparam fn_t FN_ORN   = 3'd3;
  localparam fn_t FN_XOR   = 3'd4;
  localparam fn_t FN_XORN  = 3'd5;

  localparam fn_t FN_SHL   = 3'd0;
  localparam fn_t FN_SHRL  = 3'd1;
  localparam fn_t FN_SHRA  = 3'd2;

  localparam fn_t FN_EQ    = 3'd0;
  localparam fn_t FN_LT    = 3'd1;
  localparam fn_t FN_LE    = 3'd2;
  localparam fn_t FN_ULT   = 3'd3;
  localparam fn_t FN_ULE   = 3'd4;

  localparam fn_t FN_MEQ   = 3'd0;
  localparam fn_t FN_MNE   = 3'd1;
  localparam fn_t FN_MLT   = 3'd2;
  localparam fn_t FN_MLE   = 3'd3;
  localparam fn_t FN_MGT   = 3'd4;
  localparam fn_t FN_MGE   = 3'd5;
  localparam fn_t FN_MLBC  = 3'd6;
  localparam fn_t FN_MLBS  = 3'd7;
endpackage

// File: rtl/iex_arith.sv
module iex_arith
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  fn_t               fn,
  input  logic              quad,
  input  logic              trap_en,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              ovf
);
  localparam int LW = DATA_W / 2;

  logic [DATA_W-1:0] x, y, sum;
  logic              cin;
  logic              b_neg;
  logic              ov_q, ov_l, may_trap;

  // Sign of the second operand at the selected width, used by absolute value.
  assign b_neg = quad ? b[DATA_W-1] : b[LW-1];

  // One adder serves every function; the scale and the inversion are
  // applied to its inputs.
  always_comb begin
    x   = a;
    y   = b;
    cin = 1'b0;
    case (fn)
      FN_SUB:   begin y = ~b; cin = 1'b1; end
      FN_S4ADD: x = a << 2;
      FN_S8ADD: x = a << 3;
      FN_S4SUB: begin x = a << 2; y = ~b; cin = 1'b1; end
      FN_S8SUB: begin x = a << 3; y = ~b; cin = 1'b1; end
      FN_NEG:   begin x = '0; y = ~b; cin = 1'b1; end
      FN_ABS:   begin x = '0; y = b_neg ? ~b : b; cin = b_neg; end
      default:  ;
    endcase
  end

  assign sum = x + y + {{(DATA_W-1){1'b0}}, cin};

  // Overflow: both adder inputs have the same sign and the sum's sign differs.
  assign ov_q = (x[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]);
  assign ov_l = (x[LW-1] == y[LW-1]) && (sum[LW-1] != x[LW-1]);

  // Scaled forms never trap; absolute value always may.
  assign may_trap = (fn == FN_ABS) ||
                    (trap_en && (fn == FN_ADD || fn == FN_SUB || fn == FN_NEG));

  assign ovf = may_trap && (quad ? ov_q : ov_l);
  assign res = quad ? sum : {{(DATA_W-LW){sum[LW-1]}}, sum[LW-1:0]};
endmodule

// File: rtl/iex_logic_shift.sv
module iex_logic_shift
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              is_shift,
  input  fn_t               fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              legal
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] lres, sres;
  logic              lleg, sleg;

  assign cnt = b[CNT_W-1:0];

  always_comb begin
    lres = '0;
    lleg = 1'b1;
    case (fn)
      FN_AND:  lres = a & b;
      FN_ANDN: lres = a & ~b;
      FN_OR:   lres = a | b;
      FN_ORN:  lres = a | ~b;
      FN_XOR:  lres = a ^ b;
      FN_XORN: lres = a ^ ~b;
      default: lleg = 1'b0;
    endcase
  end

  always_comb begin
    sres = '0;
    sleg = 1'b1;
    case (fn)
      FN_SHL:  sres = a << cnt;
      FN_SHRL: sres = a >> cnt;
      FN_SHRA: sres = $signed(a) >>> cnt;
      default: sleg = 1'b0;
    endcase
  end

  assign res   = is_shift ? sres : lres;
  assign legal = is_shift ? sleg : lleg;
endmodule

// File: rtl/iex_cmp_cmov.sv
module iex_cmp_cmov
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              is_cmov,
  input  fn_t               fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              wr,
  output logic              legal
);
  logic eq, slt, ult, a_zero, a_neg;
  logic flag, fleg, cond;

  assign eq     = (a == b);
  assign slt    = $signed(a) < $signed(b);
  assign ult    = a < b;
  assign a_zero = (a == '0);
  assign a_neg  = a[DATA_W-1];

  always_comb begin
    flag = 1'b0;
    fleg = 1'b1;
    case (fn)
      FN_EQ:   flag = eq;
      FN_LT:   flag = slt;
      FN_LE:   flag = slt | eq;
      FN_ULT:  flag = ult;
      FN_ULE:  flag = ult | eq;
      default: fleg = 1'b0;
    endcase
  end

  always_comb begin
    case (fn)
      FN_MEQ:  cond = a_zero;
      FN_MNE:  cond = !a_zero;
      FN_MLT:  cond = a_neg;
      FN_MLE:  cond = a_neg | a_zero;
      FN_MGT:  cond = !a_neg && !a_zero;
      FN_MGE:  cond = !a_neg;
      FN_MLBC: cond = !a[0];
      default: cond = a[0];
    endcase
  end

  assign res   = is_cmov ? b : {{(DATA_W-1){1'b0}}, flag};
  assign wr    = is_cmov ? cond : 1'b1;
  assign legal = is_cmov ? 1'b1 : fleg;
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LIT_W  = 8,
  parameter int OP_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic              trap_en,
  input  logic              quad,
  input  logic              use_lit,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [LIT_W-1:0]  lit,
  output logic              res_valid,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              ovf_trap
);
  localparam int LW = DATA_W / 2;

  cls_t              cls;
  fn_t               fn;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] ar_res, ls_res, cm_res;
  logic              ar_ovf, ls_leg, cm_leg, cm_wr;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_wr, nxt_ovf, nxt_leg;

  assign cls = op[5:3];
  assign fn  = op[2:0];
  assign opb = use_lit ? {{(DATA_W-LIT_W){1'b0}}, lit} : src_b;

  iex_arith #(.DATA_W(DATA_W)) u_arith (
    .fn(fn), .quad(quad), .trap_en(trap_en), .a(src_a), .b(opb),
    .res(ar_res), .ovf(ar_ovf)
  );

  iex_logic_shift #(.DATA_W(DATA_W)) u_logic (
    .is_shift(cls == CLS_SHIFT), .fn(fn), .a(src_a), .b(opb),
    .res(ls_res), .legal(ls_leg)
  );

  iex_cmp_cmov #(.DATA_W(DATA_W)) u_cmp (
    .is_cmov(cls == CLS_CMOV), .fn(fn), .a(src_a), .b(opb),
    .res(cm_res), .wr(cm_wr), .legal(cm_leg)
  );

  always_comb begin
    nxt_res = '0;
    nxt_wr  = 1'b0;
    nxt_ovf = 1'b0;
    nxt_leg = 1'b0;
    case (cls)
      CLS_ARITH: begin
        nxt_res = ar_res; nxt_wr = 1'b1; nxt_ovf = ar_ovf; nxt_leg = 1'b1;
      end
      CLS_LOGIC, CLS_SHIFT: begin
        nxt_res = ls_res; nxt_wr = 1'b1; nxt_leg = ls_leg;
      end
      CLS_CMP, CLS_CMOV: begin
        nxt_res = cm_res; nxt_wr = cm_wr; nxt_leg = cm_leg;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      ovf_trap  <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        result   <= nxt_leg ? nxt_res : '0;
        wr_en    <= nxt_leg & nxt_wr;
        ovf_trap <= nxt_leg & nxt_ovf;
      end else begin
        wr_en    <= 1'b0;
        ovf_trap <= 1'b0;
      end
    end
  end

  // R1: one-cycle latency, idle cycles produce no write
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && !wr_en && !ovf_trap));
  // R2: a literal second operand moved by a set-low-bit move stays within 8 bits
  p_lit_zero_ext_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && use_lit && op == {CLS_CMOV, FN_MLBS} && src_a[0])
    |=> (wr_en && result[DATA_W-1:LIT_W] == '0));
  // R3: 32-bit arithmetic results are sign-extended from bit 31
  p_long_canon_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_ARITH && !quad)
    |=> (result[DATA_W-1:LW] == {(DATA_W-LW){result[LW-1]}}));
  // R3: with trapping disabled, only absolute value can raise the flag
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_ARITH && !trap_en && fn != FN_ABS) |=> !ovf_trap);
  // R4: scaled forms never trap
  p_scaled_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_ARITH && fn >= FN_S4ADD && fn <= FN_S8SUB) |=> !ovf_trap);
  // R8: compares write 0 or 1
  p_cmp_bool_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_CMP) |=> (result[DATA_W-1:1] == '0));
  // R9: a failing set-low-bit move does not write
  p_cmov_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == {CLS_CMOV, FN_MLBS} && !src_a[0]) |=> !wr_en);
  // R10: the flag is confined to valid arithmetic results
  p_ovf_valid_r10: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> res_valid);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls != CLS_ARITH) |=> !ovf_trap);
  // R11: reserved classes write nothing
  p_reserved_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls > CLS_CMOV) |=> (!wr_en && !ovf_trap && result == '0));
endmodule

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
module int_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [5:0]  op = '0;
  logic        trap_en = 1'b0;
  logic        quad = 1'b0;
  logic        use_lit = 1'b0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [7:0]  lit = '0;
  logic        res_valid;
  logic [63:0] result;
  logic        wr_en;
  logic        ovf_trap;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  int_exec_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .trap_en(trap_en),
    .quad(quad), .use_lit(use_lit), .src_a(src_a), .src_b(src_b), .lit(lit),
    .res_valid(res_valid), .result(result), .wr_en(wr_en), .ovf_trap(ovf_trap)
  );

  function automatic string req_of(input logic [5:0] o);
    case (o[5:3])
      3'd0: return (o[2:0] <= 3'd1) ? "R3" : (o[2:0] <= 3'd5) ? "R4" : "R5";
      3'd1: return (o[2:0] <= 3'd5) ? "R6" : "R11";
      3'd2: return (o[2:0] <= 3'd2) ? "R7" : "R11";
      3'd3: return (o[2:0] <= 3'd4) ? "R8" : "R11";
      3'd4: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // Reference model written from the requirements.
  function automatic void model(input logic [5:0] o, input logic t, input logic q,
                                input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] r, output logic w, output logic v);
    logic [64:0] s65;
    logic [32:0] s33;
    logic [63:0] aa, bb;
    logic        ov;
    r = '0; w = 1'b0; v = 1'b0;
    case (o[5:3])
      3'd0: begin
        aa = q ? a : sx32(a[31:0]);
        bb = q ? b : sx32(b[31:0]);
        case (o[2:0])
          3'd0: s65 = {aa[63], aa} + {bb[63], bb};
          3'd1: s65 = {aa[63], aa} - {bb[63], bb};
          3'd2: s65 = {1'b0, aa * 4 + bb};
          3'd3: s65 = {1'b0, aa * 8 + bb};
          3'd4: s65 = {1'b0, aa * 4 - bb};
          3'd5: s65 = {1'b0, aa * 8 - bb};
          3'd6: s65 = 65'd0 - {bb[63], bb};
          default: s65 = bb[63] ? 65'd0 - {bb[63], bb} : {1'b0, bb};
        endcase
        if (q) begin
          r  = s65[63:0];
          ov = (s65[64] != s65[63]);
        end else begin
          s33 = s65[32:0];
          r  = sx32(s33[31:0]);
          ov = (s65[63:32] != {32{s65[31]}});
        end
        w = 1'b1;
        if (o[2:0] == 3'd7) v = ov;
        else if (o[2:0] <= 3'd1 || o[2:0] == 3'd6) v = ov && t;
      end
      3'd1: begin
        w = (o[2:0] <= 3'd5);
        case (o[2:0])
          3'd0: r = a & b;
          3'd1: r = a & ~b;
          3'd2: r = a | b;
          3'd3: r = a | ~b;
          3'd4: r = a ^ b;
          3'd5: r = ~(a ^ b);
          default: r = '0;
        endcase
      end
      3'd2: begin
        w = (o[2:0] <= 3'd2);
        case (o[2:0])
          3'd0: r = a << (b % 64);
          3'd1: r = a >> (b % 64);
          3'd2: r = 64'($signed(a) >>> (b % 64));
          default: r = '0;
        endcase
      end
      3'd3: begin
        w = (o[2:0] <= 3'd4);
        case (o[2:0])
          3'd0: r = {63'd0, a == b};
          3'd1: r = {63'd0, $signed(a) < $signed(b)};
          3'd2: r = {63'd0, $signed(a) <= $signed(b)};
          3'd3: r = {63'd0, a < b};
          3'd4: r = {63'd0, a <= b};
          default: r = '0;
        endcase
      end
      3'd4: begin
        r = b;
        case (o[2:0])
          3'd0: w = $signed(a) == 0;
          3'd1: w = $signed(a) != 0;
          3'd2: w = $signed(a) < 0;
          3'd3: w = $signed(a) <= 0;
          3'd4: w = $signed(a) > 0;
          3'd5: w = $signed(a) >= 0;
          3'd6: w = a[0] == 1'b0;
          default: w = a[0] == 1'b1;
        endcase
      end
      default: ;
    endcase
  endfunction

  task automatic check(input string tag, input logic [66:0] act, input logic [66:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0h act{valid,wr,ovf,res}=%h exp=%h", tag, op, act, exp);
    end
  endtask

  task automatic run(input logic [5:0] o, input logic t, input logic q,
                     input logic ul, input logic [63:0] a, input logic [63:0] b,
                     input logic [7:0] l);
    logic [63:0] er;
    logic        ew, ev;
    op = o; trap_en = t; quad = q; use_lit = ul;
    src_a = a; src_b = b; lit = l; in_valid = 1'b1;
    model(o, t, q, a, ul ? {56'd0, l} : b, er, ew, ev);
    @(negedge clk);
    check(ul ? "R2" : req_of(o), {res_valid, wr_en, ovf_trap, result},
          {1'b1, ew, ev, er});
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 7)
      0: return 64'd0;
      1: return 64'h8000_0000_0000_0000;
      2: return 64'h7fff_ffff_ffff_ffff;
      3: return 64'hffff_ffff_8000_0000;
      4: return 64'h0000_0000_7fff_ffff;
      5: return {56'd0, 8'($urandom)};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R1 watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", {res_valid, wr_en, ovf_trap, result}, 67'd0);
    rst = 1'b0;
    // R3 trapping and quiet add/sub at both widths
    run(6'o00, 1, 1, 0, 64'h7fff_ffff_ffff_ffff, 64'd1, 8'd0);
    run(6'o00, 0, 1, 0, 64'h7fff_ffff_ffff_ffff, 64'd1, 8'd0);
    run(6'o00, 1, 0, 0, 64'h1234_5678_7fff_ffff, 64'd1, 8'd0);
    run(6'o01, 1, 0, 0, 64'h0, 64'hffff_ffff_8000_0000, 8'd0);
    run(6'o01, 1, 1, 0, 64'h8000_0000_0000_0000, 64'd1, 8'd0);
    // R4 scaled, overflowing inputs stay quiet
    run(6'o03, 1, 1, 0, 64'h7fff_ffff_ffff_ffff, 64'd5, 8'd0);
    run(6'o04, 1, 0, 0, 64'h4000_0000, 64'd3, 8'd0);
    // R5 negate and absolute value at the most negative values
    run(6'o06, 1, 1, 0, 64'd0, 64'h8000_0000_0000_0000, 8'd0);
    run(6'o06, 0, 0, 0, 64'd0, 64'h0000_0000_8000_0000, 8'd0);
    run(6'o07, 0, 0, 0, 64'd0, 64'hffff_ffff_8000_0000, 8'd0);
    run(6'o07, 0, 1, 0, 64'd0, 64'hffff_ffff_ffff_fff9, 8'd0);
    // R6 complement logic, R2 literal path
    run(6'o15, 0, 0, 0, 64'hf0f0_0000_ffff_1234, 64'h0ff0_1111_0000_4321, 8'd0);
    run(6'o13, 0, 0, 1, 64'h0, 64'hffff_ffff_ffff_ffff, 8'h0f);
    // R7 counts beyond 63 are masked
    run(6'o20, 0, 0, 0, 64'h1, 64'd65, 8'd0);
    run(6'o22, 0, 0, 1, 64'h8000_0000_0000_0000, 64'd0, 8'd127);
    // R8 signed vs unsigned
    run(6'o31, 0, 0, 0, 64'hffff_ffff_ffff_ffff, 64'd1, 8'd0);
    run(6'o33, 0, 0, 0, 64'hffff_ffff_ffff_ffff, 64'd1, 8'd0);
    // R9 move taken and suppressed
    run(6'o44, 0, 0, 0, 64'd0, 64'hdead, 8'd0);
    run(6'o47, 0, 0, 1, 64'd3, 64'h0, 8'h9c);
    // R11 reserved codes
    run(6'o56, 1, 1, 0, 64'h5, 64'h7, 8'd0);
    run(6'o16, 1, 1, 0, 64'h5, 64'h7, 8'd0);
    // R1 idle cycle after a write
    in_valid = 1'b0;
    @(negedge clk);
    check("R1", {64'd0, res_valid, wr_en, ovf_trap}, 67'd0);
    // Random mix, R10 covered by every non-arithmetic case
    for (int i = 0; i < 600; i++) begin
      logic [5:0] o;
      o = ($urandom % 10 == 0) ? 6'($urandom) : {3'($urandom % 5), 3'($urandom)};
      run(o, 1'($urandom), 1'($urandom), ($urandom % 4) == 0, pick(), pick(),
          8'($urandom));
    end
    finish_run();
  end
endmodule